// File: doc/BRIEF.md
# Cartridge ROM Source Selector

This block sits on a console cartridge edge in front of two complete ROM sets: a custom set, made of an 8 KB program image and an 8 KB pattern image, and a stock set, made of a 16 KB program image and an 8 KB pattern image. It decodes the program-space chip enable from the CPU address and the phase-2 clock (`cpu_m2`). It drives separate chip-enable and output-enable lines for each of the four memories, so that only one set ever answers the CPU side and the video side.

After reset the custom set answers. Boot code in the custom image copies a short routine into internal RAM and jumps to it. That routine writes a key byte anywhere in $8000-$FFFF and then spins. The write arms a one-way handover state machine. The machine waits for the CPU clock to drop, lets a fixed settling window of `SETTLE_CLKS` master-clock cycles pass, and then switches on a master-clock edge where `cpu_m2` is low. At that point no ROM access is in flight. Program and pattern selections move together, and only a reset brings the custom set back. All inputs are sampled on `clk`, the master clock from which `cpu_m2` is divided, so no extra synchronisation is needed.

The state machine has four states. In `SEL_CUSTOM`, a key write moves it to `SEL_ARMED`. In `SEL_ARMED`, `cpu_m2` low moves it to `SEL_SETTLE`. In `SEL_SETTLE`, an elapsed window together with `cpu_m2` low moves it to `SEL_STOCK`. `SEL_STOCK` only leaves on reset.

Top module: `cart_rom_selector`

## Requirements
- R1: `prg_ce_n` is low exactly when `cpu_addr[15]` is 1 and `cpu_m2` is 1, and high otherwise.
- R2: After reset the custom set is selected. A read with `cpu_m2` high, `cpu_rw` = 1 and `cpu_addr` in $8000-$FFFF drives `cust_prg_ce_n` and `cust_prg_oe_n` low and keeps both stock program lines high.
- R3: A write (`cpu_rw` = 0, `cpu_m2` high) to $8000-$FFFF with `cpu_data` equal to `ARM_KEY` (default 8'hA5) arms the handover. The stock set becomes selected on the (`SETTLE_CLKS`+1)-th rising `clk` edge with `cpu_m2` low after the write, counting from the edge where `cpu_m2` is first seen low.
- R4: A write with any other data byte, or a write below $8000, does not arm the handover. The custom set still answers afterwards.
- R5: The selection changes only on a `clk` edge where `cpu_m2` is low. A read with `cpu_m2` high inside an unfinished or just-finished window is still served by the custom set.
- R6: Once the stock set is selected, further key writes have no effect. It stays selected until `rst_n` goes low.
- R7: While `cpu_rw` = 0, every program-ROM chip enable and output enable stays high.
- R8: Program and pattern selections always switch together. The custom program ROM and the stock pattern ROM are never enabled at once, and neither are the stock program ROM and the custom pattern ROM.
- R9: `cust_prg_addr` is `cpu_addr[12:0]`, so the 8 KB image repeats every 8 KB and $8000, $A000 and $C000 hit the same byte. `stock_prg_addr` is `cpu_addr[13:0]`.
- R10: A pattern-side read (`chr_rd_n` = 0, `chr_wr_n` = 1) with `chr_addr[13]` = 0 drives the selected pattern ROM's CE and OE low. Reads with `chr_addr[13]` = 1, and any access with `chr_wr_n` = 0, enable no pattern ROM.
- R11: While `cpu_m2` is low, no program-ROM enable line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; selects the custom set |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_m2 | input | 1 | CPU phase-2 clock; bus valid while high |
| cpu_data | input | 8 | CPU data bus, compared with the key on writes |
| chr_addr | input | 14 | Video-side address bus |
| chr_rd_n | input | 1 | Video-side read strobe, active low |
| chr_wr_n | input | 1 | Video-side write strobe, active low |
| prg_ce_n | output | 1 | Program-space decode, NOT(A15 AND M2) |
| cust_prg_ce_n | output | 1 | Custom program ROM chip enable |
| cust_prg_oe_n | output | 1 | Custom program ROM output enable |
| cust_prg_addr | output | 13 | Custom program ROM address (mirrored) |
| stock_prg_ce_n | output | 1 | Stock program ROM chip enable |
| stock_prg_oe_n | output | 1 | Stock program ROM output enable |
| stock_prg_addr | output | 14 | Stock program ROM address |
| cust_chr_ce_n | output | 1 | Custom pattern ROM chip enable |
| cust_chr_oe_n | output | 1 | Custom pattern ROM output enable |
| stock_chr_ce_n | output | 1 | Stock pattern ROM chip enable |
| stock_chr_oe_n | output | 1 | Stock pattern ROM output enable |
| chr_rom_addr | output | 13 | Pattern ROM address, shared by both sets |

## Verification
A vector table, applied in the custom state, pairs each address half ($0000-$7FFF, $8000-$FFFF) with each CPU clock phase and with reads, plain writes and key writes below $8000. This separates a correct A15/M2 decode from one that ignores either term, and it shows that a non-key write neither enables a ROM nor arms the switch. Directed sequences then arm the handover and read with `cpu_m2` high one edge before the settling window ends and again after it. This separates a switch that waits for the window and the M2-low phase from one that fires early. Further sequences try key writes in the stock state, reset, and mirrored addresses, and they probe the pattern side with reads inside and outside $0000-$1FFF and with write strobes.

// File: rtl/cart_sel_pkg.sv
package cart_sel_pkg;

    // Handover state machine encoding
    typedef enum logic [1:0] {
        SEL_CUSTOM = 2'd0,
        SEL_ARMED  = 2'd1,
        SEL_SETTLE = 2'd2,
        SEL_STOCK  = 2'd3
    } sel_state_e;

endpackage

// File: rtl/cart_bus_decode.sv
module cart_bus_decode #(
    parameter int          CPU_AW   = 16,
    parameter int          DW       = 8,
    parameter int          CUST_AW  = 13,
    parameter int          STOCK_AW = 14,
    parameter logic [7:0]  ARM_KEY  = 8'hA5
) (
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic                cpu_rw,
    input  logic                cpu_m2,
    input  logic [DW-1:0]       cpu_data,
    output logic                prg_ce_n,
    output logic                rom_rd,
    output logic                key_wr,
    output logic [CUST_AW-1:0]  cust_addr,
    output logic [STOCK_AW-1:0] stock_addr
);

    localparam int TOP_BIT = CPU_AW - 1;

    logic hi_half;
    logic bus_live;
    logic key_match;
    logic unused_addr_bits;

    always_comb begin
        hi_half   = cpu_addr[TOP_BIT];
        bus_live  = hi_half & cpu_m2;
        key_match = (cpu_data == DW'(ARM_KEY));
        // Program-space decode: active low, only in the M2-high phase
        prg_ce_n  = ~bus_live;
        // ROM read window: upper half, bus valid, CPU reading
        rom_rd    = bus_live & cpu_rw;
        // Control write: upper half, bus valid, CPU writing the key
        key_wr    = bus_live & ~cpu_rw & key_match;
    end

    // Smaller images repeat across the upper half
    assign cust_addr  = cpu_addr[CUST_AW-1:0];
    assign stock_addr = cpu_addr[STOCK_AW-1:0];

    assign unused_addr_bits = ^cpu_addr;

endmodule

// File: rtl/cart_handover_fsm.sv
module cart_handover_fsm
    import cart_sel_pkg::*;
#(
    parameter int SETTLE_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_m2,
    input  logic key_wr,
    output logic use_stock
);

    localparam int CW = $clog2(SETTLE_CLKS) + 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CLKS - 1);

    sel_state_e       state_q;
    sel_state_e       state_d;
    logic [CW-1:0]    cnt_q;
    logic             window_done;

    assign window_done = (cnt_q == LAST);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_CUSTOM: if (key_wr)                 state_d = SEL_ARMED;
            SEL_ARMED:  if (!cpu_m2)                state_d = SEL_SETTLE;
            SEL_SETTLE: if (window_done && !cpu_m2) state_d = SEL_STOCK;
            SEL_STOCK:                              state_d = SEL_STOCK;
            default:                                state_d = SEL_CUSTOM;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_CUSTOM;
        end else begin
            state_q <= state_d;
        end
    end

    // Settling window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == SEL_SETTLE) begin
            if (!window_done) cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SEL_STOCK: use_stock = 1'b1;
            default:   use_stock = 1'b0;
        endcase
    end

    AST_SWITCH_M2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_stock) |-> !$past(cpu_m2)); // R5

    AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(use_stock) |-> use_stock); // R6

    AST_SWITCH_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_stock) |-> $past(state_q) == SEL_SETTLE); // R3

endmodule

// File: rtl/cart_enable_route.sv
module cart_enable_route #(
    parameter int CHR_AW = 14
) (
    input  logic              use_stock,
    input  logic              rom_rd,
    input  logic [CHR_AW-1:0] chr_addr,
    input  logic              chr_rd_n,
    input  logic              chr_wr_n,
    output logic              cust_prg_ce_n,
    output logic              cust_prg_oe_n,
    output logic              stock_prg_ce_n,
    output logic              stock_prg_oe_n,
    output logic              cust_chr_ce_n,
    output logic              cust_chr_oe_n,
    output logic              stock_chr_ce_n,
    output logic              stock_chr_oe_n
);

    localparam int PAT_BIT = CHR_AW - 1;

    logic pat_rd;
    logic cust_prg_on;
    logic stock_prg_on;
    logic cust_chr_on;
    logic stock_chr_on;

    always_comb begin
        // Pattern space read, with no write strobe present
        pat_rd       = ~chr_addr[PAT_BIT] & ~chr_rd_n & chr_wr_n;
        cust_prg_on  = rom_rd & ~use_stock;
        stock_prg_on = rom_rd & use_stock;
        cust_chr_on  = pat_rd & ~use_stock;
        stock_chr_on = pat_rd & use_stock;

        cust_prg_ce_n  = ~cust_prg_on;
        cust_prg_oe_n  = ~cust_prg_on;
        stock_prg_ce_n = ~stock_prg_on;
        stock_prg_oe_n = ~stock_prg_on;
        cust_chr_ce_n  = ~cust_chr_on;
        cust_chr_oe_n  = ~cust_chr_on;
        stock_chr_ce_n = ~stock_chr_on;
        stock_chr_oe_n = ~stock_chr_on;
    end

endmodule

// File: rtl/cart_rom_selector.sv
module cart_rom_selector #(
    parameter int         CPU_AW      = 16,
    parameter int         DW          = 8,
    parameter int         CUST_AW     = 13,
    parameter int         STOCK_AW    = 14,
    parameter int         CHR_AW      = 14,
    parameter int         SETTLE_CLKS = 6,
    parameter logic [7:0] ARM_KEY     = 8'hA5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic                cpu_rw,
    input  logic                cpu_m2,
    input  logic [DW-1:0]       cpu_data,
    input  logic [CHR_AW-1:0]   chr_addr,
    input  logic                chr_rd_n,
    input  logic                chr_wr_n,
    output logic                prg_ce_n,
    output logic                cust_prg_ce_n,
    output logic                cust_prg_oe_n,
    output logic [CUST_AW-1:0]  cust_prg_addr,
    output logic                stock_prg_ce_n,
    output logic                stock_prg_oe_n,
    output logic [STOCK_AW-1:0] stock_prg_addr,
    output logic                cust_chr_ce_n,
    output logic                cust_chr_oe_n,
    output logic                stock_chr_ce_n,
    output logic                stock_chr_oe_n,
    output logic [CHR_AW-2:0]   chr_rom_addr
);

    logic rom_rd;
    logic key_wr;
    logic use_stock;

    cart_bus_decode #(
        .CPU_AW   (CPU_AW),
        .DW       (DW),
        .CUST_AW  (CUST_AW),
        .STOCK_AW (STOCK_AW),
        .ARM_KEY  (ARM_KEY)
    ) u_decode (
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .cpu_m2     (cpu_m2),
        .cpu_data   (cpu_data),
        .prg_ce_n   (prg_ce_n),
        .rom_rd     (rom_rd),
        .key_wr     (key_wr),
        .cust_addr  (cust_prg_addr),
        .stock_addr (stock_prg_addr)
    );

    cart_handover_fsm #(
        .SETTLE_CLKS (SETTLE_CLKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_m2    (cpu_m2),
        .key_wr    (key_wr),
        .use_stock (use_stock)
    );

    cart_enable_route #(
        .CHR_AW (CHR_AW)
    ) u_route (
        .use_stock      (use_stock),
        .rom_rd         (rom_rd),
        .chr_addr       (chr_addr),
        .chr_rd_n       (chr_rd_n),
        .chr_wr_n       (chr_wr_n),
        .cust_prg_ce_n  (cust_prg_ce_n),
        .cust_prg_oe_n  (cust_prg_oe_n),
        .stock_prg_ce_n (stock_prg_ce_n),
        .stock_prg_oe_n (stock_prg_oe_n),
        .cust_chr_ce_n  (cust_chr_ce_n),
        .cust_chr_oe_n  (cust_chr_oe_n),
        .stock_chr_ce_n (stock_chr_ce_n),
        .stock_chr_oe_n (stock_chr_oe_n)
    );

    assign chr_rom_addr = chr_addr[CHR_AW-2:0];

    AST_NO_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> (cust_prg_ce_n && cust_prg_oe_n && stock_prg_ce_n && stock_prg_oe_n)); // R7

    AST_M2_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_m2 |-> (cust_prg_ce_n && stock_prg_ce_n && prg_ce_n)); // R11

    AST_SETS_TOGETHER_A: assert property (@(posedge clk) disable iff (!rst_n)
        !cust_prg_ce_n |-> stock_chr_ce_n); // R8

    AST_SETS_TOGETHER_B: assert property (@(posedge clk) disable iff (!rst_n)
        !stock_prg_ce_n |-> cust_chr_ce_n); // R8

    AST_ROM_NEEDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cust_prg_ce_n || !stock_prg_ce_n) |-> !prg_ce_n); // R1

endmodule

// File: tb/cart_rom_selector_test.sv
module cart_rom_selector_test;

    localparam int S = 6;
    localparam logic [7:0] KEY = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic [7:0]  cpu_data = 8'h00;
    logic [13:0] chr_addr = 14'h0000;
    logic        chr_rd_n = 1'b1;
    logic        chr_wr_n = 1'b1;
    logic        prg_ce_n, cust_prg_ce_n, cust_prg_oe_n, stock_prg_ce_n, stock_prg_oe_n;
    logic [12:0] cust_prg_addr;
    logic [13:0] stock_prg_addr;
    logic        cust_chr_ce_n, cust_chr_oe_n, stock_chr_ce_n, stock_chr_oe_n;
    logic [12:0] chr_rom_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cart_rom_selector #(.SETTLE_CLKS(S), .ARM_KEY(KEY)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_m2(cpu_m2), .cpu_data(cpu_data), .chr_addr(chr_addr),
        .chr_rd_n(chr_rd_n), .chr_wr_n(chr_wr_n), .prg_ce_n(prg_ce_n),
        .cust_prg_ce_n(cust_prg_ce_n), .cust_prg_oe_n(cust_prg_oe_n),
        .cust_prg_addr(cust_prg_addr), .stock_prg_ce_n(stock_prg_ce_n),
        .stock_prg_oe_n(stock_prg_oe_n), .stock_prg_addr(stock_prg_addr),
        .cust_chr_ce_n(cust_chr_ce_n), .cust_chr_oe_n(cust_chr_oe_n),
        .stock_chr_ce_n(stock_chr_ce_n), .stock_chr_oe_n(stock_chr_oe_n),
        .chr_rom_addr(chr_rom_addr)
    );

    // {prg_ce_n, cust ce, cust oe, stock ce, stock oe}
    localparam logic [4:0] P_CUST  = 5'b00011;
    localparam logic [4:0] P_STOCK = 5'b01100;
    localparam logic [4:0] P_NONE  = 5'b11111;
    localparam logic [4:0] P_DEC   = 5'b01111;

    // {addr[15:0], rw, m2, data[7:0], expected[4:0]} applied in the custom state
    localparam int NV = 8;
    localparam logic [30:0] VEC [NV] = '{
        {16'h8000, 1'b1, 1'b1, 8'h00, P_CUST},  // R1 R2 read upper, M2 high
        {16'hC123, 1'b1, 1'b1, 8'h00, P_CUST},  // R2 mirror half
        {16'h8000, 1'b1, 1'b0, 8'h00, P_NONE},  // R11 M2 low
        {16'h7FFF, 1'b1, 1'b1, 8'h00, P_NONE},  // R1 lower half
        {16'h0000, 1'b1, 1'b1, 8'h00, P_NONE},  // R1 lower half
        {16'h9000, 1'b0, 1'b1, 8'h00, P_DEC},   // R4 R7 non-key write
        {16'h6000, 1'b0, 1'b1, KEY,   P_NONE},  // R4 key write below $8000
        {16'hFFFC, 1'b1, 1'b1, 8'h00, P_CUST}   // R2 vector area
    };

    function automatic logic [4:0] prg_bits();
        return {prg_ce_n, cust_prg_ce_n, cust_prg_oe_n, stock_prg_ce_n, stock_prg_oe_n};
    endfunction

    function automatic logic [3:0] chr_bits();
        return {cust_chr_ce_n, cust_chr_oe_n, stock_chr_ce_n, stock_chr_oe_n};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive the CPU side just after a falling edge; settle 1 ns before looking
    task automatic cpu(input logic [15:0] a, input logic rw, input logic m2, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_m2 = m2; cpu_data = d;
        #1;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_idle(input int n);
        cpu(16'h0000, 1'b1, 1'b0, 8'h00);
        if (n > 1) hold(n - 1);
    endtask

    task automatic chr(input logic [13:0] a, input logic rd_n, input logic wr_n);
        @(negedge clk);
        chr_addr = a; chr_rd_n = rd_n; chr_wr_n = wr_n;
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset state: custom set answers (R2)
        cpu(16'h8000, 1'b1, 1'b1, 8'h00);
        check("R2 reset", 16'(prg_bits()), 16'(P_CUST));
        hold(2);
        rst_n = 1'b1;
        bus_idle(2);

        // Table walk in the custom state
        for (int i = 0; i < NV; i++) begin
            cpu(VEC[i][30:15], VEC[i][14], VEC[i][13], VEC[i][12:5]);
            check("R1/R2/R4/R7 vector", 16'(prg_bits()), 16'(VEC[i][4:0]));
            hold(2);
            bus_idle(S + 3);
        end

        // R4: after the non-key writes, custom still answers
        cpu(16'h8000, 1'b1, 1'b1, 8'h00);
        check("R4 not armed", 16'(prg_bits()), 16'(P_CUST));
        bus_idle(1);

        // R9: mirrored addresses
        cpu(16'hA005, 1'b1, 1'b1, 8'h00);
        check("R9 cust addr", 16'(cust_prg_addr), 16'h0005);
        check("R9 stock addr", 16'(stock_prg_addr), 16'h2005);
        cpu(16'hC005, 1'b1, 1'b1, 8'h00);
        check("R9 stock mirror", 16'(stock_prg_addr), 16'h0005);

        // R10: pattern side in the custom state
        chr(14'h0123, 1'b0, 1'b1);
        check("R10 custom chr read", 16'(chr_bits()), 16'h3);
        check("R10 chr addr", 16'(chr_rom_addr), 16'h0123);
        chr(14'h2000, 1'b0, 1'b1);
        check("R10 above pattern", 16'(chr_bits()), 16'hF);
        chr(14'h0010, 1'b1, 1'b0);
        check("R10 chr write", 16'(chr_bits()), 16'hF);
        chr(14'h0000, 1'b1, 1'b1);

        // R3/R5: arm, then read one edge before the switch may happen
        bus_idle(2);
        cpu(16'h8000, 1'b0, 1'b1, KEY);
        check("R7 key write no enable", 16'(prg_bits()), 16'(P_DEC));
        hold(2);
        bus_idle(S);          // S rising edges with M2 low: window not past
        cpu(16'h8000, 1'b1, 1'b1, 8'h00);
        check("R3 not yet switched", 16'(prg_bits()), 16'(P_CUST));
        hold(2);              // window finished but M2 high: must wait (R5)
        check("R5 hold while M2 high", 16'(prg_bits()), 16'(P_CUST));
        bus_idle(2);
        cpu(16'h8000, 1'b1, 1'b1, 8'h00);
        check("R3 switched", 16'(prg_bits()), 16'(P_STOCK));

        // R8: pattern side follows
        chr(14'h0456, 1'b0, 1'b1);
        check("R8 stock chr read", 16'(chr_bits()), 16'hC);
        chr(14'h0000, 1'b1, 1'b1);

        // R6: further key writes change nothing
        bus_idle(1);
        cpu(16'hFFFF, 1'b0, 1'b1, KEY);
        hold(1);
        bus_idle(S + 4);
        cpu(16'hC000, 1'b1, 1'b1, 8'h00);
        check("R6 stays stock", 16'(prg_bits()), 16'(P_STOCK));
        bus_idle(1);

        // R6/R2: reset brings back the custom set
        rst_n = 1'b0;
        hold(2);
        rst_n = 1'b1;
        cpu(16'h8000, 1'b1, 1'b1, 8'h00);
        check("R2 after reset", 16'(prg_bits()), 16'(P_CUST));
        bus_idle(2);

        finished = 1;
        summary();
        $finish;
    end

endmodule